// File: doc/BRIEF.md
# Single-Ramp Correlated Double Sampling Sequencer

This block is the digital controller of one column converter in an image sensor readout. The analog side holds two levels on capacitors, the pixel reset level and the pixel signal level, and feeds them with a single falling ramp into a difference amplifier. The amplifier's input pairs are steered by four switches. The sequencer first closes the sampling switches to capture both levels. It then steers the amplifier so that the ramp is compared against the held reset level. When that comparison trips, it reroutes the amplifier onto the held pixel level and counts clock cycles until the second comparison trips. The count is the digital difference between the two levels, so offsets common to both levels cancel without a second ramp.

A conversion starts with a one-cycle `start` pulse in idle. The comparator output `cmp` is read every clock. `sync` is high from the first crossing until the second, and the counter advances only while it is high. When the conversion ends, the block returns the steering switches to their parked pattern, presents `code` together with a one-cycle `done` pulse, and waits for the next `start`.

Top module: `cds_ramp_seq`

## Requirements
- R1: After reset and while idle, `samp_sw` is 4'b0000, `steer_sw` is the parked pattern 4'b0101, and `sync`, `done` and `ramp_run` are low, with `code` reading 0 after reset.
- R2: A `start` pulse in idle opens a sampling phase of HOLD_CYC cycles with `samp_sw` = 4'b0101 (bits 0 and 2 hold the reset level), then HOLD_CYC cycles with `samp_sw` = 4'b1010 (bits 1 and 3 hold the pixel level). `steer_sw` stays 4'b0101 throughout sampling.
- R3: In the reset-compare phase, `samp_sw` is 4'b0000, `steer_sw` is 4'b1001, `ramp_run` is high and `sync` is low. `cmp` high means the ramp has reached the level currently selected by the steering.
- R4: The cycle after `cmp` is first seen high in reset-compare, `sync` rises and `steer_sw` is 4'b0000 for exactly one break cycle. In the next cycle `steer_sw` becomes 4'b0110 and pixel-compare begins.
- R5: In pixel-compare the counter starts at 0 and advances once per cycle in which `cmp` is low. In the first cycle with `cmp` high, `sync` falls and `code` takes the count. With the ramp falling one step per cycle, a level difference of D steps gives `code` = D-2.
- R6: If `cmp` is already high on the first pixel-compare cycle (pixel level equal to, or within two steps of, the reset level, or above it), `code` is 0.
- R7: `ramp_run` never stays high for more than 2^CODE_W consecutive cycles. If the pixel crossing has not happened by the last cycle of that window, `code` saturates at 2^CODE_W-1 and `done` is still given.
- R8: If no reset crossing occurs within the ramp window, the conversion ends with `code` = 0, and `sync` never rises.
- R9: The conversion ends with a single-cycle `done` pulse, during which `steer_sw` is back to 4'b0101 and `sync` is low. `code` changes only in a `done` cycle and holds until the next one.
- R10: A `start` pulse during a conversion is ignored: exactly one `done` follows each accepted `start`, and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion (accepted only in idle) |
| cmp | input | 1 | Amplifier decision: ramp has reached the selected held level |
| samp_sw | output | 4 | Sampling switches; bits 0 and 2 hold the reset level, bits 1 and 3 hold the pixel level |
| steer_sw | output | 4 | Amplifier steering switches: 0101 parked, 1001 reset-compare, 0110 pixel-compare, 0000 break |
| ramp_run | output | 1 | Ramp generator runs (falls one step per cycle) while high |
| sync | output | 1 | High between the reset crossing and the pixel crossing |
| code | output | CODE_W | Converted difference, valid in the `done` cycle and held afterwards |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The hardest cases to reach are the ones where the two crossings fall together or never happen. Examples are a pixel level equal to or just below the reset level, where the pixel decision is already true on the first counting cycle, and levels placed outside the ramp's travel, which drive the window expiry in either compare phase. The bench models the amplifier as a ramp that falls one step per cycle while `ramp_run` is high. It compares that ramp against whichever held level the steering pattern selects. Placing the two levels at chosen distances, including negative ones and a pixel level above the reset level, produces each of these endings. The expected code and ramp length follow from the requirements in closed form.

// File: rtl/cds_seq_pkg.sv
// Shared types and switch patterns for the single-ramp CDS sequencer.
// Assumes: steering bit order {3:0} is fixed by the analog column wiring.
package cds_seq_pkg;

    // Conversion phases, visited in this order.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SMP_RST,
        PH_SMP_PIX,
        PH_RCMP,
        PH_BRK,
        PH_PCMP,
        PH_FIN
    } phase_e;

    // How a conversion ended.
    typedef enum logic [1:0] {
        FIN_HIT,   // pixel crossing seen: code = count
        FIN_SAT,   // window expired after reset crossing: code = max
        FIN_MISS   // no reset crossing in window: code = 0
    } fin_e;

    // Steering patterns of the difference amplifier input pairs.
    localparam logic [3:0] STEER_PARK = 4'b0101;
    localparam logic [3:0] STEER_RST  = 4'b1001;
    localparam logic [3:0] STEER_PIX  = 4'b0110;
    localparam logic [3:0] STEER_OPEN = 4'b0000;

    // Sampling switch patterns.
    localparam logic [3:0] SAMP_NONE  = 4'b0000;
    localparam logic [3:0] SAMP_RST   = 4'b0101;
    localparam logic [3:0] SAMP_PIX   = 4'b1010;

    // Decoded drive of all analog-facing controls.
    typedef struct packed {
        logic [3:0] samp;
        logic [3:0] steer;
        logic       ramp;
        logic       sync;
        logic       done;
    } drive_t;

endpackage

// File: rtl/cds_phase_fsm.sv
// Phase controller: steps through sampling, reset-compare, break,
// pixel-compare and finish. Tracks the sampling hold time and the ramp
// window. Emits one finish strobe with the reason the conversion ended.
// Assumes: cmp is synchronous to clk; ramp falls one step per ramp cycle.
module cds_phase_fsm
    import cds_seq_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int HOLD_CYC = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   cmp,
    output phase_e phase,
    output logic   fin_valid,
    output fin_e   fin_kind,
    output logic   cnt_clr,
    output logic   cnt_en
);

    localparam int              HOLD_W    = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);
    localparam logic [CODE_W-1:0] TICK_LAST = '1;

    phase_e            nxt;
    logic [HOLD_W-1:0] hold_q;
    logic [CODE_W-1:0] tick_q;
    logic              tick_last;
    logic              hold_end;
    logic              on_ramp;
    logic              sampling;

    assign tick_last = (tick_q == TICK_LAST);
    assign hold_end  = (hold_q == HOLD_LAST);
    assign on_ramp   = (phase == PH_RCMP) || (phase == PH_BRK) || (phase == PH_PCMP);
    assign sampling  = (phase == PH_SMP_RST) || (phase == PH_SMP_PIX);

    // Next phase and finish reason.
    always_comb begin
        nxt       = phase;
        fin_valid = 1'b0;
        fin_kind  = FIN_HIT;
        case (phase)
            PH_IDLE:    if (start) nxt = PH_SMP_RST;
            PH_SMP_RST: if (hold_end) nxt = PH_SMP_PIX;
            PH_SMP_PIX: if (hold_end) nxt = PH_RCMP;
            PH_RCMP: begin
                if (tick_last) begin
                    nxt       = PH_FIN;
                    fin_valid = 1'b1;
                    fin_kind  = cmp ? FIN_SAT : FIN_MISS;
                end else if (cmp) begin
                    nxt = PH_BRK;
                end
            end
            PH_BRK: begin
                if (tick_last) begin
                    nxt       = PH_FIN;
                    fin_valid = 1'b1;
                    fin_kind  = FIN_SAT;
                end else begin
                    nxt = PH_PCMP;
                end
            end
            PH_PCMP: begin
                if (cmp) begin
                    nxt       = PH_FIN;
                    fin_valid = 1'b1;
                    fin_kind  = FIN_HIT;
                end else if (tick_last) begin
                    nxt       = PH_FIN;
                    fin_valid = 1'b1;
                    fin_kind  = FIN_SAT;
                end
            end
            PH_FIN:     nxt = PH_IDLE;
            default:    nxt = PH_IDLE;
        endcase
    end

    // Counter controls: clear in the break cycle, count while pixel not reached.
    assign cnt_clr = (phase == PH_BRK);
    assign cnt_en  = (phase == PH_PCMP) && !cmp;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    // Sampling hold timer, restarted on every phase change.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_q <= '0;
        else if (nxt != phase)   hold_q <= '0;
        else if (sampling)       hold_q <= hold_q + 1'b1;
    end

    // Ramp window position, zero whenever the ramp is parked.
    always_ff @(posedge clk) begin
        if (!rst_n || !on_ramp) tick_q <= '0;
        else                    tick_q <= tick_q + 1'b1;
    end

endmodule

// File: rtl/cds_code_counter.sv
// Sync-gated counter and output code register.
// Assumes: cnt_clr and cnt_en are never high together; fin_valid is a
// one-cycle strobe on the edge that enters the finish phase.
module cds_code_counter
    import cds_seq_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clr,
    input  logic              cnt_en,
    input  logic              fin_valid,
    input  fin_e              fin_kind,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CODE_W-1:0] count_q;

    // Saturating count of pixel-compare cycles before the crossing.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr)             count_q <= '0;
        else if (cnt_en && count_q != CODE_MAX) count_q <= count_q + 1'b1;
    end

    // Output code, updated only when a conversion finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (fin_valid) begin
            case (fin_kind)
                FIN_HIT:  code <= count_q;
                FIN_SAT:  code <= CODE_MAX;
                FIN_MISS: code <= '0;
                default:  code <= '0;
            endcase
        end
    end

endmodule

// File: rtl/cds_switch_decode.sv
// Maps the current phase onto sampling switches, steering switches,
// ramp enable, sync and done. Purely combinational.
// Assumes: phase comes straight from a register, so outputs change once per clock.
module cds_switch_decode
    import cds_seq_pkg::*;
(
    input  phase_e phase,
    output drive_t drv
);

    // Phase-to-switch table.
    always_comb begin
        drv       = '0;
        drv.samp  = SAMP_NONE;
        drv.steer = STEER_PARK;
        case (phase)
            PH_SMP_RST: drv.samp = SAMP_RST;
            PH_SMP_PIX: drv.samp = SAMP_PIX;
            PH_RCMP: begin
                drv.steer = STEER_RST;
                drv.ramp  = 1'b1;
            end
            PH_BRK: begin
                drv.steer = STEER_OPEN;
                drv.ramp  = 1'b1;
                drv.sync  = 1'b1;
            end
            PH_PCMP: begin
                drv.steer = STEER_PIX;
                drv.ramp  = 1'b1;
                drv.sync  = 1'b1;
            end
            PH_FIN:  drv.done = 1'b1;
            default: drv.steer = STEER_PARK;
        endcase
    end

endmodule

// File: rtl/cds_ramp_seq.sv
// Top of the single-ramp CDS sequencer: phase controller, sync-gated
// counter and switch decoder. One conversion per accepted start pulse.
// Assumes: cmp reflects the ramp against the level selected by steer_sw.
module cds_ramp_seq
    import cds_seq_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp,
    output logic [3:0]        samp_sw,
    output logic [3:0]        steer_sw,
    output logic              ramp_run,
    output logic              sync,
    output logic [CODE_W-1:0] code,
    output logic              done
);

    phase_e phase;
    logic   fin_valid;
    fin_e   fin_kind;
    logic   cnt_clr;
    logic   cnt_en;
    drive_t drv;

    cds_phase_fsm #(
        .CODE_W   (CODE_W),
        .HOLD_CYC (HOLD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmp       (cmp),
        .phase     (phase),
        .fin_valid (fin_valid),
        .fin_kind  (fin_kind),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en)
    );

    cds_code_counter #(
        .CODE_W (CODE_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en),
        .fin_valid (fin_valid),
        .fin_kind  (fin_kind),
        .code      (code)
    );

    cds_switch_decode u_dec (
        .phase (phase),
        .drv   (drv)
    );

    // Drive the ports from the decoded pattern.
    assign samp_sw  = drv.samp;
    assign steer_sw = drv.steer;
    assign ramp_run = drv.ramp;
    assign sync     = drv.sync;
    assign done     = drv.done;

endmodule

// File: rtl/cds_ramp_seq_chk.sv
// Property checker for cds_ramp_seq, attached by bind.
module cds_ramp_seq_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp,
    input logic [3:0]        samp_sw,
    input logic [3:0]        steer_sw,
    input logic              ramp_run,
    input logic              sync,
    input logic [CODE_W-1:0] code,
    input logic              done
);

    localparam int RUN_W = CODE_W + 2;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(1 << CODE_W);

    logic [RUN_W-1:0] run_len;

    // Length of the current ramp run so far.
    always_ff @(posedge clk) begin
        if (!rst_n || !ramp_run)  run_len <= '0;
        else if (run_len != '1)   run_len <= run_len + 1'b1;
    end

    assert_ramp_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_run |-> (run_len < RUN_MAX));

    assert_no_samp_on_ramp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_run |-> (samp_sw == 4'b0000));

    assert_samp_pairs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_sw == 4'b0000) || (samp_sw == 4'b0101) || (samp_sw == 4'b1010));

    assert_rst_cross_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_sw == 4'b1001 && cmp && ramp_run) |=> (sync || done));

    assert_break_then_pix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_sw == 4'b0000) |=> (steer_sw == 4'b0110 || done));

    assert_sync_rise_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> (steer_sw == 4'b0000));

    assert_pix_cross_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_sw == 4'b0110 && cmp) |=> (done && !sync));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (steer_sw == 4'b0101 && !sync && !ramp_run));

    assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> done);

endmodule

bind cds_ramp_seq cds_ramp_seq_chk #(
    .CODE_W (CODE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp      (cmp),
    .samp_sw  (samp_sw),
    .steer_sw (steer_sw),
    .ramp_run (ramp_run),
    .sync     (sync),
    .code     (code),
    .done     (done)
);

// File: tb/cds_ramp_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them on every done pulse. The amplifier is a ramp model.
module cds_ramp_seq_bench;

    localparam int CODE_W   = 10;
    localparam int HOLD_CYC = 4;
    localparam int TOP      = (1 << CODE_W) - 1;
    localparam int WIN      = 1 << CODE_W;

    typedef struct {
        int    exp_code;
        int    exp_ramp;
        string tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cmp;
    logic [3:0]        samp_sw;
    logic [3:0]        steer_sw;
    logic              ramp_run;
    logic              sync;
    logic [CODE_W-1:0] code;
    logic              done;

    int    checks = 0;
    int    errors = 0;
    int    lvl_r = 0;
    int    lvl_p = 0;
    int    btick = 0;
    int    ramp_cnt = 0;
    int    done_cnt = 0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    cds_ramp_seq #(
        .CODE_W   (CODE_W),
        .HOLD_CYC (HOLD_CYC)
    ) u_cds_ramp_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp      (cmp),
        .samp_sw  (samp_sw),
        .steer_sw (steer_sw),
        .ramp_run (ramp_run),
        .sync     (sync),
        .code     (code),
        .done     (done)
    );

    // Ramp model: falls one step per cycle while ramp_run is high.
    always @(posedge clk) begin
        if (!rst_n || !ramp_run) btick <= 0;
        else                     btick <= btick + 1;
    end

    // Amplifier model: compares the ramp with the level selected by steering.
    always_comb begin
        case (steer_sw)
            4'b1001: cmp = ((TOP - btick) <= lvl_r);
            4'b0110: cmp = ((TOP - btick) <= lvl_p);
            default: cmp = 1'b0;
        endcase
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected code from the requirements.
    function automatic int exp_code(input int r, input int p);
        if (r < 0)          return 0;          // R8
        if (r <= 1)         return TOP;        // R7, no room after crossing
        if (p < 0)          return TOP;        // R7
        if (r - p <= 2)     return 0;          // R6
        return r - p - 2;                      // R5
    endfunction

    // Expected number of ramp_run cycles.
    function automatic int exp_ramp(input int r, input int p);
        if (r < 0 || r <= 1 || p < 0) return WIN;
        if (r - p <= 2)               return TOP + 3 - r;
        return WIN - p;
    endfunction

    // Driver: push the expectation, pulse start, optionally check sampling
    // sequence and poke start while busy, then wait for the result.
    task automatic run_conv(input int r, input int p, input string tag,
                            input bit chk_seq, input bit poke);
        item_t it;
        it.exp_code = exp_code(r, p);
        it.exp_ramp = exp_ramp(r, p);
        it.tag      = tag;
        sb_q.push_back(it);
        lvl_r = r;
        lvl_p = p;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (chk_seq) begin
            for (int i = 0; i < HOLD_CYC; i++) begin
                check(samp_sw == 4'b0101 && steer_sw == 4'b0101, "R2",
                      "reset-hold pattern", {samp_sw, steer_sw}, 8'h55);
                @(negedge clk);
            end
            for (int i = 0; i < HOLD_CYC; i++) begin
                check(samp_sw == 4'b1010 && steer_sw == 4'b0101, "R2",
                      "pixel-hold pattern", {samp_sw, steer_sw}, 8'hA5);
                @(negedge clk);
            end
            check(samp_sw == 4'b0000 && steer_sw == 4'b1001 && ramp_run && !sync,
                  "R3", "reset-compare pattern",
                  {samp_sw, steer_sw, ramp_run, sync}, 10'h026);
        end
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: ramp length, break-cycle sync, and result comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ramp_run) ramp_cnt++;
            if (ramp_run && steer_sw == 4'b0000 && !sync) begin
                check(1'b0, "R4", "sync during break", 0, 1);
            end
            if (done) begin
                done_cnt++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(int'(code) == it.exp_code, it.tag, "code",
                          int'(code), it.exp_code);
                    check(ramp_cnt == it.exp_ramp, "R7", "ramp cycles",
                          ramp_cnt, it.exp_ramp);
                    check(!sync && steer_sw == 4'b0101, "R9", "finish pattern",
                          {sync, steer_sw}, 5);
                end
                ramp_cnt = 0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus.
    initial begin
        int dn;
        int held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset and idle state
        check(samp_sw == 4'b0000 && steer_sw == 4'b0101 && !sync && !done &&
              !ramp_run && code == '0, "R1", "idle outputs",
              {samp_sw, steer_sw, sync, done, ramp_run}, 8'h05 << 3);
        repeat (3) @(negedge clk);
        check(!ramp_run && steer_sw == 4'b0101, "R1", "idle without start",
              {ramp_run, steer_sw}, 5);

        run_conv(800, 500, "R5", 1'b1, 1'b0);
        run_conv(1000, 100, "R5", 1'b0, 1'b0);
        run_conv(303, 300, "R5", 1'b0, 1'b0);
        run_conv(1023, 0, "R5", 1'b0, 1'b0);
        run_conv(300, 300, "R6", 1'b1, 1'b0);
        run_conv(301, 300, "R6", 1'b0, 1'b0);
        run_conv(302, 300, "R6", 1'b0, 1'b0);
        run_conv(500, 700, "R6", 1'b0, 1'b0);
        run_conv(600, -50, "R7", 1'b0, 1'b0);

        // R9: code holds and done stays low while idle
        held = int'(code);
        repeat (6) @(negedge clk);
        check(int'(code) == held && !done && steer_sw == 4'b0101, "R9",
              "code held in idle", int'(code), held);

        // R8: no reset crossing; sync must stay low
        run_conv(-10, -20, "R8", 1'b0, 1'b0);

        // R10: start while busy is ignored
        dn = done_cnt;
        run_conv(700, 200, "R10", 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        check(done_cnt == dn + 1 && !ramp_run, "R10", "single done per start",
              done_cnt - dn, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // R8: sync never rises while the reset level is out of the ramp range.
    always @(negedge clk) begin
        if (rst_n && lvl_r < 0 && sync) begin
            check(1'b0, "R8", "sync rose without reset crossing", 1, 0);
        end
    end

endmodule